// File: doc/BRIEF.md
# Interrupt Presenter Priority Logic

This block presents interrupts to one hardware thread running an operating-system context. Notification events arrive on a stream input, each carrying a priority number in which a smaller value is more favored. Every valid level sets one bit in an eight-level pending bitmap. Priority 0 owns the top bit and priority 7 owns the bottom bit. Events accumulate by OR. From this bitmap the block keeps a pending-priority register. It holds the count of leading zeros of the bitmap, which is the most favored pending level, or 0xFF when nothing is pending.

Software programs a current processor priority through a plain write port. Values above 7 are refused. Whenever a new event is accepted or the current priority is accepted, the block compares the resulting pending priority against the resulting current priority. If the pending priority is strictly smaller, the block sets the exception-present flag in its status register and raises `irq`. That flag and `irq` are sticky: nothing inside this block lowers them, only reset. The current priority resets to 0, which masks every level.

The event input is a valid/ready stream. `ev_ready` is held high, so the block never applies back-pressure, and an event is taken on every clock edge where `ev_valid` is high. A combinational read port returns one of four registers, selected by `rd_sel`.

Top module: `irq_prio_presenter`

## Requirements
- R1: After reset, the pending bitmap reads 0x00, the pending priority 0xFF, the current priority 0x00, the status 0x00, and `irq` is low. Reset is asynchronous and active low.
- R2: An accepted event with priority p in 0..7 sets bit (7 − p) of the pending bitmap, visible on the read port after the next rising edge. So p=0 sets bit 7 (0x80) and p=7 sets bit 0 (0x01).
- R3: Pending bits accumulate by OR and are never cleared except by reset, including when events arrive on back-to-back cycles.
- R4: The pending priority equals the number of leading zeros of the 8-bit pending bitmap. It reads 0xFF when the bitmap is empty.
- R5: An event whose priority is 0xFF (masked) or any value from 8 to 0xFE leaves the pending bitmap and pending priority unchanged.
- R6: A current-priority write with data above 7 is refused and the register keeps its value. A write with data 0..7 is stored.
- R7: One rising edge after an accepted event or write leaves pending priority < current priority, status bit 7 reads 1 and `irq` is high. Equal values do not signal.
- R8: A write that raises the current priority above an already present pending priority signals on its own, with no new event.
- R9: Once raised, `irq` and status bit 7 stay high until reset, even if the current priority is later written to 0.
- R10: `ev_ready` is always high, and every cycle with `ev_valid` high delivers one event.
- R11: An event and a current-priority write in the same cycle are both applied. The comparison uses both new values.
- R12: Read select codes: 0 returns the pending bitmap, 1 the pending priority, 2 the current priority, 3 the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present on the stream input |
| ev_ready | output | 1 | Event accepted; held high |
| ev_prio | input | 8 | Priority carried by the event |
| cppr_we | input | 1 | Current-priority write strobe |
| cppr_wdata | input | 8 | Current-priority write data |
| rd_sel | input | 2 | Register select for the read port |
| rd_data | output | 8 | Selected register value |
| irq | output | 1 | Interrupt to the thread, sticky |

## Verification
On every cycle, the assertions check the following:
- the pending bitmap only gains bits;
- out-of-range events leave it untouched;
- the pending priority always points at the highest set bit, or is 0xFF when the bitmap is empty;
- the current priority never holds a value above 7, and refused writes leave it stable;
- `irq` never falls once raised, and it only rises when the pending priority is strictly below the current priority.

Only the bench scenarios show the following:
- the exact bit chosen for each priority;
- the strict-versus-equal boundary;
- the one-edge latency;
- same-cycle event and write handling;
- the values returned on the read port.

// File: rtl/ipp_pkg.sv
package ipp_pkg;
  localparam int PRIO_LEVELS = 8;
  localparam int REG_W       = 8;
  localparam logic [REG_W-1:0] PIPR_EMPTY = '1;
  localparam int STAT_EO_BIT = 7;

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_PIPR = 2'd1,
    SEL_CPPR = 2'd2,
    SEL_STAT = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/ipp_lzc.sv
// Leading-zero count over the pending bitmap; all-zero yields all ones.
module ipp_lzc #(
  parameter int LEVELS = ipp_pkg::PRIO_LEVELS,
  parameter int W      = ipp_pkg::REG_W
) (
  input  logic [LEVELS-1:0] vec,
  output logic [W-1:0]      cnt
);
  always_comb begin
    cnt = '1;
    // Higher bits are visited last, so the most favored level wins.
    for (int i = 0; i < LEVELS; i++) begin
      if (vec[i]) cnt = W'(LEVELS - 1 - i);
    end
  end
endmodule

// File: rtl/ipp_pend_buf.sv
// Pending bitmap with registered most-favored priority.
module ipp_pend_buf #(
  parameter int LEVELS = ipp_pkg::PRIO_LEVELS,
  parameter int W      = ipp_pkg::REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_fire,
  input  logic [W-1:0]      ev_prio,
  output logic              ev_lands,
  output logic [LEVELS-1:0] pend_q,
  output logic [W-1:0]      pipr_q,
  output logic [W-1:0]      pipr_nxt
);
  logic [LEVELS-1:0] set_vec;
  logic [LEVELS-1:0] pend_nxt;

  // Level p maps to bit LEVELS-1-p; out-of-range priorities decode to nothing.
  for (genvar g = 0; g < LEVELS; g++) begin : g_dec
    assign set_vec[g] = ev_fire && (ev_prio == W'(LEVELS - 1 - g));
  end

  assign ev_lands = |set_vec;
  assign pend_nxt = pend_q | set_vec;

  ipp_lzc #(.LEVELS(LEVELS), .W(W)) u_lzc (
    .vec (pend_nxt),
    .cnt (pipr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pipr_q <= '1;
    end else begin
      pend_q <= pend_nxt;
      pipr_q <= pipr_nxt;
    end
  end
endmodule

// File: rtl/ipp_cppr_reg.sv
// Current processor priority with range check on writes.
module ipp_cppr_reg #(
  parameter int LEVELS = ipp_pkg::PRIO_LEVELS,
  parameter int W      = ipp_pkg::REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic         wr_ok,
  output logic [W-1:0] cppr_q,
  output logic [W-1:0] cppr_nxt
);
  assign wr_ok    = we && (wdata < W'(LEVELS));
  assign cppr_nxt = wr_ok ? wdata : cppr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cppr_q <= '0;
    else        cppr_q <= cppr_nxt;
  end
endmodule

// File: rtl/ipp_notify.sv
// Sticky exception flag, re-evaluated on each accepted update.
module ipp_notify #(
  parameter int W = ipp_pkg::REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig,
  input  logic [W-1:0] pipr_nxt,
  input  logic [W-1:0] cppr_nxt,
  output logic         eo_q
);
  logic fire;
  assign fire = trig && (pipr_nxt < cppr_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    eo_q <= 1'b0;
    else if (fire) eo_q <= 1'b1;
  end
endmodule

// File: rtl/irq_prio_presenter.sv
module irq_prio_presenter
  import ipp_pkg::*;
#(
  parameter int LEVELS = PRIO_LEVELS,
  parameter int W      = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_valid,
  output logic         ev_ready,
  input  logic [W-1:0] ev_prio,
  input  logic         cppr_we,
  input  logic [W-1:0] cppr_wdata,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  logic              ev_fire;
  logic              ev_lands;
  logic [LEVELS-1:0] pend_q;
  logic [W-1:0]      pipr_q;
  logic [W-1:0]      pipr_nxt;
  logic              cppr_ok;
  logic [W-1:0]      cppr_q;
  logic [W-1:0]      cppr_nxt;
  logic              eo_q;
  logic [W-1:0]      stat;

  assign ev_ready = 1'b1;
  assign ev_fire  = ev_valid && ev_ready;

  ipp_pend_buf #(.LEVELS(LEVELS), .W(W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_fire  (ev_fire),
    .ev_prio  (ev_prio),
    .ev_lands (ev_lands),
    .pend_q   (pend_q),
    .pipr_q   (pipr_q),
    .pipr_nxt (pipr_nxt)
  );

  ipp_cppr_reg #(.LEVELS(LEVELS), .W(W)) u_cppr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cppr_we),
    .wdata    (cppr_wdata),
    .wr_ok    (cppr_ok),
    .cppr_q   (cppr_q),
    .cppr_nxt (cppr_nxt)
  );

  ipp_notify #(.W(W)) u_notify (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (ev_lands || cppr_ok),
    .pipr_nxt (pipr_nxt),
    .cppr_nxt (cppr_nxt),
    .eo_q     (eo_q)
  );

  always_comb begin
    stat = '0;
    stat[STAT_EO_BIT] = eo_q;
  end

  always_comb begin
    case (rd_sel_e'(rd_sel))
      SEL_PEND: rd_data = W'(pend_q);
      SEL_PIPR: rd_data = pipr_q;
      SEL_CPPR: rd_data = cppr_q;
      default:  rd_data = stat;
    endcase
  end

  assign irq = eo_q;
endmodule

// File: rtl/irq_prio_presenter_chk.sv
module irq_prio_presenter_chk #(
  parameter int LEVELS = ipp_pkg::PRIO_LEVELS,
  parameter int W      = ipp_pkg::REG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic [W-1:0]      ev_prio,
  input logic              cppr_we,
  input logic [W-1:0]      cppr_wdata,
  input logic [LEVELS-1:0] pend,
  input logic [W-1:0]      pipr,
  input logic [W-1:0]      cppr,
  input logic              irq
);
  AST_PEND_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend)) == $past(pend)));  // R3
  AST_PIPR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (pipr == '1));  // R4
  AST_PIPR_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> ((pipr < W'(LEVELS)) && ((pend >> (LEVELS - 1 - int'(pipr))) == 1)));  // R4
  AST_BAD_EVENT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && (ev_prio >= W'(LEVELS))) |=> (pend == $past(pend)));  // R5
  AST_CPPR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cppr < W'(LEVELS));  // R6
  AST_CPPR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr_we && (cppr_wdata >= W'(LEVELS))) |=> $stable(cppr));  // R6
  AST_IRQ_RISE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((pipr < cppr) && $past(ev_valid || cppr_we)));  // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq);  // R9
endmodule

bind irq_prio_presenter irq_prio_presenter_chk #(.LEVELS(LEVELS), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_valid   (ev_valid),
  .ev_prio    (ev_prio),
  .cppr_we    (cppr_we),
  .cppr_wdata (cppr_wdata),
  .pend       (pend_q),
  .pipr       (pipr_q),
  .cppr       (cppr_q),
  .irq        (irq)
);

// File: tb/irq_prio_presenter_bench.sv
module irq_prio_presenter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [7:0] ev_prio = 8'h00;
  logic       cppr_we = 1'b0;
  logic [7:0] cppr_wdata = 8'h00;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_prio_presenter u_irq_prio_presenter (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_prio(ev_prio), .cppr_we(cppr_we), .cppr_wdata(cppr_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  typedef struct packed {
    logic       rst;
    logic       ev_v;
    logic [7:0] ev_p;
    logic       we;
    logic [7:0] wd;
    logic [7:0] x_pend;
    logic [7:0] x_pipr;
    logic [7:0] x_cppr;
    logic       x_irq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 4'd1},  // R1 reset values
    '{1'b0, 1'b1, 8'h03, 1'b0, 8'h00, 8'h10, 8'h03, 8'h00, 1'b0, 4'd2},  // R2 p3 -> bit4, cppr 0 masks
    '{1'b0, 1'b1, 8'h06, 1'b0, 8'h00, 8'h12, 8'h03, 8'h00, 1'b0, 4'd3},  // R3 accumulate
    '{1'b0, 1'b1, 8'hFF, 1'b0, 8'h00, 8'h12, 8'h03, 8'h00, 1'b0, 4'd5},  // R5 masked
    '{1'b0, 1'b1, 8'h09, 1'b0, 8'h00, 8'h12, 8'h03, 8'h00, 1'b0, 4'd5},  // R5 out of range
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'h08, 8'h12, 8'h03, 8'h00, 1'b0, 4'd6},  // R6 refused
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'h03, 8'h12, 8'h03, 8'h03, 1'b0, 4'd7},  // R7 equal: no signal
    '{1'b0, 1'b1, 8'h05, 1'b0, 8'h00, 8'h16, 8'h03, 8'h03, 1'b0, 4'd7},  // R7 still equal
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'h04, 8'h16, 8'h03, 8'h04, 1'b1, 4'd8},  // R8 write fires
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 8'h16, 8'h03, 8'h00, 1'b1, 4'd9},  // R9 sticky
    '{1'b0, 1'b1, 8'h07, 1'b0, 8'h00, 8'h17, 8'h03, 8'h00, 1'b1, 4'd9},  // R9 sticky
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 4'd1},  // R1 reset clears
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'h07, 8'h00, 8'hFF, 8'h07, 1'b0, 4'd4},  // R4 empty -> FF
    '{1'b0, 1'b1, 8'h07, 1'b0, 8'h00, 8'h01, 8'h07, 8'h07, 1'b0, 4'd7},  // R7 7 vs 7 no signal
    '{1'b0, 1'b1, 8'h06, 1'b0, 8'h00, 8'h03, 8'h06, 8'h07, 1'b1, 4'd7},  // R7 event fires
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 4'd1},  // R1
    '{1'b0, 1'b1, 8'h02, 1'b1, 8'h05, 8'h20, 8'h02, 8'h05, 1'b1, 4'd11}, // R11 same cycle
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 4'd1},  // R1
    '{1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h80, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 p0 -> MSB
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'h01, 8'h80, 8'h00, 8'h01, 1'b1, 4'd8},  // R8
    '{1'b0, 1'b1, 8'h08, 1'b1, 8'hFF, 8'h80, 8'h00, 8'h01, 1'b1, 4'd6}   // R6 R5 both refused
  };

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R12 read select codes: 0 pend, 1 pipr, 2 cppr, 3 status
  task automatic read_regs(output logic [7:0] p, output logic [7:0] pi,
                           output logic [7:0] c, output logic [7:0] s);
    rd_sel = 2'd0; #1 p  = rd_data;
    rd_sel = 2'd1; #1 pi = rd_data;
    rd_sel = 2'd2; #1 c  = rd_data;
    rd_sel = 2'd3; #1 s  = rd_data;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic step(input vec_t v);
    logic [7:0] p, pi, c, s;
    if (v.rst) begin
      pulse_reset();
    end else begin
      @(negedge clk);
      ev_valid = v.ev_v; ev_prio = v.ev_p; cppr_we = v.we; cppr_wdata = v.wd;
      chk(10, "ev_ready", {7'd0, ev_ready}, 8'h01);  // R10
      @(negedge clk);
      ev_valid = 1'b0; cppr_we = 1'b0;
    end
    read_regs(p, pi, c, s);
    chk(int'(v.req), "pend", p, v.x_pend);
    chk(int'(v.req), "pipr", pi, v.x_pipr);
    chk(int'(v.req), "cppr", c, v.x_cppr);
    chk(int'(v.req), "status", s, {v.x_irq, 7'd0});
    chk(int'(v.req), "irq", {7'd0, irq}, {7'd0, v.x_irq});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] p, pi, c, s;
    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R3 R10: events on three consecutive edges all land
    pulse_reset();
    @(negedge clk); ev_valid = 1'b1; ev_prio = 8'h01;
    @(negedge clk); ev_prio = 8'h04;
    @(negedge clk); ev_prio = 8'h05;
    @(negedge clk); ev_valid = 1'b0;
    read_regs(p, pi, c, s);
    chk(3, "back-to-back pend", p, 8'h4C);
    chk(4, "back-to-back pipr", pi, 8'h01);
    chk(10, "back-to-back irq", {7'd0, irq}, 8'h00);

    // R7: one-edge latency from event to irq
    pulse_reset();
    @(negedge clk); cppr_we = 1'b1; cppr_wdata = 8'h02;
    @(negedge clk); cppr_we = 1'b0; ev_valid = 1'b1; ev_prio = 8'h01;
    #2 chk(7, "irq before edge", {7'd0, irq}, 8'h00);
    @(negedge clk); ev_valid = 1'b0;
    chk(7, "irq after edge", {7'd0, irq}, 8'h01);
    rd_sel = 2'd3; #1 chk(7, "status EO bit7", rd_data, 8'h80);

    // R1: asynchronous reset drops irq mid-cycle
    #2 rst_n = 1'b0;
    #1 chk(1, "async reset irq", {7'd0, irq}, 8'h00);
    read_regs(p, pi, c, s);
    chk(1, "async reset pend", p, 8'h00);
    chk(1, "async reset pipr", pi, 8'hFF);
    @(negedge clk); rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule